// File: doc/BRIEF.md
# Parallel ATA Host Port Engine with Ultra DMA

This block is the host side of one parallel ATA channel. It runs programmed register cycles and Ultra DMA bursts over a shared 16-bit data bus. For a register cycle, the host raises a request carrying a read/write flag, a target select, a 3-bit address and write data. The engine then drives one of two active-low chip selects and the address. It strobes the read or write command pin for a programmable number of clocks, framed by programmable setup and recovery periods. It answers with a one-clock acknowledge and, for reads, the captured word.

A pulse on `dma_start` begins a burst, in the direction given by `dma_to_dev`. The engine waits for the device request and asserts the DMA acknowledge. It then gives the two command pins new roles. The write command pin becomes an active-high stop line: it is high from idle, it drops to open the burst and it rises again to end it. On transfers toward the device, the read command pin becomes a data strobe. It changes level once for every word taken from the `tx_*` stream and holds still while no word is available. On transfers from the device, the read command pin becomes an active-low ready line. Every level change on `ata_rdy` (the device strobe) captures one word into a receive FIFO, which the host drains through the `rx_*` stream. The ready line goes high once the FIFO holds a high-water count of words, and the FIFO keeps room for words the device already had in flight. A stop request, or the device dropping its request, ends the burst. The engine raises stop, waits for the request to fall and then releases the acknowledge.

All pins are modelled as synchronous to `clk`.

Top module: `ata_host_port`

## Requirements
- R1: While neither a register cycle nor a burst is in progress, `ata_cs_n`=2'b11, `ata_rd_n`=1, `ata_wr_n`=1, `ata_ack_n`=1 and `ata_d_oe`=0.
- R2: Each timing value of 0 counts as 1. A register cycle has a setup phase of `t_setup` clocks, a strobe-low phase of exactly `t_active` clocks and a recovery phase of `t_recov` clocks. `reg_ack` is high for one clock, in the clock that follows the last recovery clock.
- R3: Throughout a register cycle, `reg_sel`=0 drives `ata_cs_n`=2'b10 and `reg_sel`=1 drives 2'b01. `ata_addr` carries the request address, and neither output changes until the cycle ends. At no time are both selects low.
- R4: In a register read, only `ata_rd_n` pulses, and `reg_rdata` holds the bus value present in the last strobe-low clock, which is the one just before the rising edge of the pin.
- R5: In a register write, only `ata_wr_n` pulses, and `ata_d_oe`=1 with `ata_d_o`=`reg_wdata` for every clock of the cycle. The bus is never driven while `ata_rd_n` is low in register mode.
- R6: `ata_ack_n` falls only after `ata_req` was seen high. In the first acknowledged clock, `ata_wr_n` (stop) and `ata_rd_n` are both still high. `ata_wr_n` falls in the next clock.
- R7: In a burst toward the device, `ata_rd_n` changes level in the clock after each `tx_valid`&&`tx_ready` handshake and at no other time, and it carries that word on `ata_d_o`.
- R8: In a burst from the device, each rising or falling change of `ata_rdy` captures `ata_d_i` as one word. The words leave on `rx_data` in arrival order.
- R9: In a burst from the device with stop low, `ata_rd_n` is high exactly while the FIFO holds at least `RX_HWM` words and low otherwise. The burst resumes once the host drains the FIFO.
- R10: After the pause, up to `RX_DEPTH`-`RX_HWM` further words are accepted without loss.
- R11: `dma_stop` raises `ata_wr_n` in the next clock. `ata_ack_n` stays low until `ata_req` is seen low, and rises in the following clock. The pins and `dma_active` then return to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register cycle request, held until `reg_ack` |
| reg_write | input | 1 | 1 = register write, 0 = register read |
| reg_sel | input | 1 | Chip select choice (0 = first, 1 = second) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_ack | output | 1 | One-clock cycle completion |
| reg_rdata | output | DW | Captured register read data |
| t_setup | input | TW | Setup clocks |
| t_active | input | TW | Strobe-low clocks |
| t_recov | input | TW | Recovery clocks |
| dma_start | input | 1 | Burst start pulse |
| dma_to_dev | input | 1 | Burst direction, 1 = toward device |
| dma_stop | input | 1 | Host request to end the burst |
| dma_active | output | 1 | Burst in progress |
| tx_data | input | DW | Outgoing burst word |
| tx_valid | input | 1 | Outgoing word valid |
| tx_ready | output | 1 | Outgoing word taken |
| rx_data | output | DW | Received burst word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Host takes received word |
| ata_d_i | input | DW | Data bus input |
| ata_d_o | output | DW | Data bus output |
| ata_d_oe | output | 1 | Data bus output enable |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_addr | output | 3 | Register address pins |
| ata_rd_n | output | 1 | Read command / ready / data strobe |
| ata_wr_n | output | 1 | Write command / stop |
| ata_ack_n | output | 1 | Active-low DMA acknowledge |
| ata_req | input | 1 | Device DMA request |
| ata_rdy | input | 1 | Device data strobe for bursts from the device |

## Verification
Most faults in the engine's state show up at the pins within one clock. A phase counter that runs long or short changes the strobe width or the delay to `reg_ack`. A wrong capture point gives a wrong `reg_rdata`, because the bench drives the true data only while the strobe is low. In a burst, a strobe state that toggles without a handshake, or freezes, shows up as a mismatch against the bench's handshake record in the very next clock. A wrong FIFO count or high-water compare moves the first pause away from the fourth word, or loses or reorders the words drained afterwards. A burst state that advances early lets the acknowledge rise while the request is still high.

// File: rtl/ata_port_pkg.sv
package ata_port_pkg;

  typedef enum logic [1:0] {RC_IDLE, RC_SETUP, RC_ACTIVE, RC_RECOV} rc_state_t;

  typedef enum logic [2:0] {DM_IDLE, DM_WAITREQ, DM_ACK, DM_XFER, DM_STOP, DM_REL} dm_state_t;

  // A programmed phase count of zero still lasts one clock.
  function automatic int phase_len(input int count);
    return (count == 0) ? 1 : count;
  endfunction

  // Receive buffer has reached its pause threshold.
  function automatic logic over_mark(input int level, input int mark);
    return level >= mark;
  endfunction

endpackage

// File: rtl/ata_reg_seq.sv
module ata_reg_seq
  import ata_port_pkg::*;
#(
  parameter int DW = 16,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic          sel,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] ts,
  input  logic [TW-1:0] ta,
  input  logic [TW-1:0] tr,
  input  logic [DW-1:0] bus_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [1:0]    cs_n,
  output logic [2:0]    addr_o,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] d_o,
  output logic          d_oe
);

  rc_state_t     st;
  logic [TW-1:0] cnt;
  logic          wr_q, sel_q;
  logic [2:0]    addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] ts_q, ta_q, tr_q;

  // named phase-end events
  logic last_s, last_a, last_r, strobe_rise;
  assign last_s      = (int'(cnt) + 1) >= phase_len(int'(ts_q));
  assign last_a      = (int'(cnt) + 1) >= phase_len(int'(ta_q));
  assign last_r      = (int'(cnt) + 1) >= phase_len(int'(tr_q));
  assign strobe_rise = (st == RC_ACTIVE) && last_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RC_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      wr_q    <= 1'b0;
      sel_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ts_q    <= '0;
      ta_q    <= '0;
      tr_q    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        RC_IDLE: if (start) begin
          wr_q    <= wr;
          sel_q   <= sel;
          addr_q  <= addr;
          wdata_q <= wdata;
          ts_q    <= ts;
          ta_q    <= ta;
          tr_q    <= tr;
          cnt     <= '0;
          st      <= RC_SETUP;
        end
        RC_SETUP: if (last_s) begin
          cnt <= '0;
          st  <= RC_ACTIVE;
        end else cnt <= cnt + 1'b1;
        RC_ACTIVE: if (strobe_rise) begin
          cnt <= '0;
          st  <= RC_RECOV;
          if (!wr_q) rdata <= bus_in;
        end else cnt <= cnt + 1'b1;
        RC_RECOV: if (last_r) begin
          st   <= RC_IDLE;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= RC_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (st != RC_IDLE);
    cs_n   = busy ? (sel_q ? 2'b01 : 2'b10) : 2'b11;
    addr_o = busy ? addr_q : 3'd0;
    rd_n   = !((st == RC_ACTIVE) && !wr_q);
    wr_n   = !((st == RC_ACTIVE) && wr_q);
    d_o    = wdata_q;
    d_oe   = busy && wr_q;
  end

  // target pins may not move inside a cycle
  assert_hold_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(cs_n) && $stable(addr_o)));

endmodule

// File: rtl/ata_rx_fifo.sv
module ata_rx_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (level == '0);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (level < LW'(DEPTH)));

endmodule

// File: rtl/ata_udma_eng.sv
module ata_udma_eng
  import ata_port_pkg::*;
#(
  parameter int DW  = 16,
  parameter int LW  = 4,
  parameter int HWM = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          to_dev,
  input  logic          stop_req,
  input  logic          dev_req,
  input  logic          dev_strobe,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic [LW-1:0] rx_level,
  output logic          tx_ready,
  output logic          ack_n,
  output logic          host_pin,
  output logic          stop_pin,
  output logic [DW-1:0] d_o,
  output logic          d_oe,
  output logic          active,
  output logic          rx_push,
  output logic [DW-1:0] rx_din
);

  dm_state_t     st;
  logic          dir_q;
  logic          strobe;
  logic          rdy_q;
  logic          in_burst, strobe_edge, pause, tx_take;

  always_comb begin
    in_burst    = (st == DM_ACK) || (st == DM_XFER) || (st == DM_STOP);
    strobe_edge = dev_strobe ^ rdy_q;
    pause       = over_mark(int'(rx_level), HWM);
    tx_ready    = dir_q && (st == DM_XFER) && !stop_req && dev_req;
    tx_take     = tx_ready && tx_valid;
    ack_n       = !in_burst;
    stop_pin    = (st != DM_XFER);
    if (dir_q) host_pin = in_burst ? strobe : 1'b1;
    else       host_pin = (st == DM_XFER) ? pause : 1'b1;
    d_oe        = dir_q && in_burst;
    active      = (st != DM_IDLE);
    rx_push     = !dir_q && ((st == DM_XFER) || (st == DM_STOP)) && strobe_edge;
    rx_din      = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DM_IDLE;
      dir_q  <= 1'b0;
      strobe <= 1'b1;
      rdy_q  <= 1'b0;
      d_o    <= '0;
    end else begin
      rdy_q <= dev_strobe;
      unique case (st)
        DM_IDLE: if (start) begin
          dir_q <= to_dev;
          st    <= DM_WAITREQ;
        end
        DM_WAITREQ: if (dev_req) st <= DM_ACK;
        DM_ACK: begin
          strobe <= 1'b1;
          st     <= DM_XFER;
        end
        DM_XFER: begin
          if (stop_req || !dev_req) st <= DM_STOP;
          else if (tx_take) begin
            d_o    <= tx_data;
            strobe <= ~strobe;
          end
        end
        DM_STOP: if (!dev_req) st <= DM_REL;
        DM_REL: begin
          strobe <= 1'b1;
          st     <= DM_IDLE;
        end
        default: st <= DM_IDLE;
      endcase
    end
  end

  assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> ($past(dev_req) && stop_pin && host_pin));

  assert_toggle_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == DM_XFER) && dir_q && (strobe != $past(strobe))) |-> $past(tx_valid));

  assert_release_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_n) |-> (!$past(dev_req) && $past(stop_pin)));

endmodule

// File: rtl/ata_host_port.sv
module ata_host_port #(
  parameter int DW       = 16,
  parameter int TW       = 4,
  parameter int RX_DEPTH = 8,
  parameter int RX_HWM   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_req,
  input  logic          reg_write,
  input  logic          reg_sel,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          reg_ack,
  output logic [DW-1:0] reg_rdata,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_active,
  input  logic [TW-1:0] t_recov,
  input  logic          dma_start,
  input  logic          dma_to_dev,
  input  logic          dma_stop,
  output logic          dma_active,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  input  logic [DW-1:0] ata_d_i,
  output logic [DW-1:0] ata_d_o,
  output logic          ata_d_oe,
  output logic [1:0]    ata_cs_n,
  output logic [2:0]    ata_addr,
  output logic          ata_rd_n,
  output logic          ata_wr_n,
  output logic          ata_ack_n,
  input  logic          ata_req,
  input  logic          ata_rdy
);

  localparam int LW = $clog2(RX_DEPTH) + 1;

  logic          reg_busy, reg_start, dma_go;
  logic          r_rd_n, r_wr_n, r_oe;
  logic [DW-1:0] r_d;
  logic          u_host, u_stop, u_oe, rx_push, rx_empty, rx_pop;
  logic [DW-1:0] u_d, rx_din;
  logic [LW-1:0] rx_level;

  // register cycles take priority; neither starts while the other runs
  assign reg_start = reg_req && !reg_busy && !reg_ack && !dma_active;
  assign dma_go    = dma_start && !dma_active && !reg_busy && !reg_start;
  assign rx_valid  = !rx_empty;
  assign rx_pop    = rx_valid && rx_ready;

  ata_reg_seq #(.DW(DW), .TW(TW)) u_reg (
    .clk(clk), .rst_n(rst_n), .start(reg_start), .wr(reg_write), .sel(reg_sel),
    .addr(reg_addr), .wdata(reg_wdata), .ts(t_setup), .ta(t_active), .tr(t_recov),
    .bus_in(ata_d_i), .busy(reg_busy), .done(reg_ack), .rdata(reg_rdata),
    .cs_n(ata_cs_n), .addr_o(ata_addr), .rd_n(r_rd_n), .wr_n(r_wr_n),
    .d_o(r_d), .d_oe(r_oe));

  ata_udma_eng #(.DW(DW), .LW(LW), .HWM(RX_HWM)) u_dma (
    .clk(clk), .rst_n(rst_n), .start(dma_go), .to_dev(dma_to_dev), .stop_req(dma_stop),
    .dev_req(ata_req), .dev_strobe(ata_rdy), .bus_in(ata_d_i), .tx_data(tx_data),
    .tx_valid(tx_valid), .rx_level(rx_level), .tx_ready(tx_ready), .ack_n(ata_ack_n),
    .host_pin(u_host), .stop_pin(u_stop), .d_o(u_d), .d_oe(u_oe), .active(dma_active),
    .rx_push(rx_push), .rx_din(rx_din));

  ata_rx_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din), .pop(rx_pop),
    .dout(rx_data), .level(rx_level), .empty(rx_empty));

  // pin role switch
  always_comb begin
    ata_rd_n = dma_active ? u_host : r_rd_n;
    ata_wr_n = dma_active ? u_stop : r_wr_n;
    ata_d_o  = dma_active ? u_d    : r_d;
    ata_d_oe = dma_active ? u_oe   : r_oe;
  end

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_active && !reg_busy) |->
      (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n && ata_ack_n && !ata_d_oe));

  assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ata_cs_n) <= 1);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n && !dma_active) |-> !ata_d_oe);

endmodule

// File: tb/tb_ata_host_port.sv
module tb_ata_host_port;
  localparam int DW = 16, TW = 4, DEPTH = 8, HWM = 4;

  typedef struct packed {
    logic          wr;
    logic          sel;
    logic [2:0]    a;
    logic [15:0]   data;
    logic [3:0]    ts;
    logic [3:0]    ta;
    logic [3:0]    tr;
  } vec_t;

  localparam logic [32:0] VT [6] = '{
    {1'b0, 1'b0, 3'd7, 16'h1F2E, 4'd1, 4'd3, 4'd1},
    {1'b1, 1'b1, 3'd2, 16'hBEEF, 4'd2, 4'd2, 4'd2},
    {1'b0, 1'b1, 3'd5, 16'h8001, 4'd0, 4'd0, 4'd0},
    {1'b1, 1'b0, 3'd0, 16'h0123, 4'd0, 4'd5, 4'd3},
    {1'b0, 1'b0, 3'd1, 16'h5A5A, 4'd4, 4'd1, 4'd0},
    {1'b1, 1'b1, 3'd6, 16'h7E81, 4'd3, 4'd15, 4'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          reg_req = 0, reg_write = 0, reg_sel = 0;
  logic [2:0]    reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic          reg_ack;
  logic [TW-1:0] t_setup = 0, t_active = 0, t_recov = 0;
  logic          dma_start = 0, dma_to_dev = 0, dma_stop = 0, dma_active;
  logic [DW-1:0] tx_data = 0, rx_data;
  logic          tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [DW-1:0] ata_d_i = 0, ata_d_o;
  logic          ata_d_oe, ata_rd_n, ata_wr_n, ata_ack_n;
  logic [1:0]    ata_cs_n;
  logic [2:0]    ata_addr;
  logic          ata_req = 0, ata_rdy = 0;

  int nchk = 0, nerr = 0;

  ata_host_port #(.DW(DW), .TW(TW), .RX_DEPTH(DEPTH), .RX_HWM(HWM)) dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_write(reg_write), .reg_sel(reg_sel),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .t_setup(t_setup), .t_active(t_active), .t_recov(t_recov), .dma_start(dma_start),
    .dma_to_dev(dma_to_dev), .dma_stop(dma_stop), .dma_active(dma_active),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .ata_d_i(ata_d_i), .ata_d_o(ata_d_o),
    .ata_d_oe(ata_d_oe), .ata_cs_n(ata_cs_n), .ata_addr(ata_addr), .ata_rd_n(ata_rd_n),
    .ata_wr_n(ata_wr_n), .ata_ack_n(ata_ack_n), .ata_req(ata_req), .ata_rdy(ata_rdy));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int plen(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic logic [15:0] wword(input int k);
    return 16'hA000 + 16'(k * 16'h0111);
  endfunction

  function automatic logic [15:0] rword(input int k);
    return 16'h3C00 ^ 16'(k * 16'h1111);
  endfunction

  task automatic idle_check(input string tag);
    chk({"R1 selects ", tag}, ata_cs_n, 2'b11);
    chk({"R1 pins ", tag}, {ata_rd_n, ata_wr_n, ata_ack_n, ata_d_oe}, 4'b1110);
  endtask

  task automatic run_reg(input vec_t v);
    int n = 0, low = 0, wrong = 0, bad_sel = 0, bad_bus = 0;
    @(negedge clk);
    reg_write = v.wr; reg_sel = v.sel; reg_addr = v.a; reg_wdata = v.data;
    t_setup = v.ts; t_active = v.ta; t_recov = v.tr;
    ata_d_i = ~v.data;
    reg_req = 1'b1;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (reg_ack) break;
      if (ata_cs_n != (v.sel ? 2'b01 : 2'b10) || ata_addr != v.a) bad_sel++;
      if (v.wr) begin
        if (!ata_wr_n) low++;
        if (!ata_rd_n) wrong++;
        if (!ata_d_oe || ata_d_o != v.data) bad_bus++;
      end else begin
        if (!ata_rd_n) low++;
        if (!ata_wr_n) wrong++;
        if (ata_d_oe) bad_bus++;
      end
      ata_d_i = (!ata_rd_n) ? v.data : ~v.data;
    end
    reg_req = 1'b0;
    chk("R2 cycle length", n, plen(v.ts) + plen(v.ta) + plen(v.tr) + 1);
    chk("R2 strobe low clocks", low, plen(v.ta));
    chk("R3 select and address held", bad_sel, 0);
    if (v.wr) begin
      chk("R5 read pin quiet in write", wrong, 0);
      chk("R5 write data driven", bad_bus, 0);
    end else begin
      chk("R4 write pin quiet in read", wrong, 0);
      chk("R4 bus released in read", bad_bus, 0);
      chk("R4 read data at strobe rise", reg_rdata, v.data);
    end
    @(negedge clk);
    idle_check("after register cycle");
  endtask

  task automatic write_burst();
    int idx = 0, got = 0, cyc = 0, bad_tog = 0, bad_dat = 0;
    logic prev_rd, hs, tog;
    @(negedge clk);
    dma_to_dev = 1'b1; dma_start = 1'b1;
    @(negedge clk);
    dma_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 ack waits for request", ata_ack_n, 1);
    chk("R11 active while waiting", dma_active, 1);
    ata_req = 1'b1;
    @(negedge clk);
    chk("R6 ack low", ata_ack_n, 0);
    chk("R6 stop high at ack", ata_wr_n, 1);
    chk("R6 strobe high at ack", ata_rd_n, 1);
    prev_rd = ata_rd_n;
    while (got < 6 && cyc < 200) begin
      tx_valid = (idx < 6) && (cyc % 3 != 2);
      tx_data  = wword(idx);
      #1 hs = tx_valid && tx_ready;
      @(negedge clk);
      cyc++;
      if (cyc == 1) chk("R6 stop falls after ack", ata_wr_n, 0);
      tog = (ata_rd_n != prev_rd);
      prev_rd = ata_rd_n;
      if (tog != hs) bad_tog++;
      if (tog) begin
        if (ata_d_o != wword(got) || !ata_d_oe || ata_wr_n) bad_dat++;
        got++;
      end
      if (hs) idx++;
    end
    tx_valid = 1'b0;
    chk("R7 words strobed", got, 6);
    chk("R7 toggle only on handshake", bad_tog, 0);
    chk("R7 data with strobe", bad_dat, 0);
    dma_stop = 1'b1;
    @(negedge clk);
    dma_stop = 1'b0;
    chk("R11 stop raised", ata_wr_n, 1);
    repeat (3) @(negedge clk);
    chk("R11 ack held while request high", ata_ack_n, 0);
    ata_req = 1'b0;
    @(negedge clk);
    chk("R11 ack released", ata_ack_n, 1);
    @(negedge clk);
    chk("R11 burst finished", dma_active, 0);
    idle_check("after write burst");
  endtask

  task automatic read_burst();
    int sent = 0, extra = 0, recv = 0, cyc = 0, bad = 0, hold = 0;
    logic paused = 1'b0, resumed = 1'b0;
    @(negedge clk);
    rx_ready = 1'b0;
    dma_to_dev = 1'b0; dma_start = 1'b1; ata_req = 1'b1;
    @(negedge clk);
    dma_start = 1'b0;
    while (recv < 10 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (extra == 2 && !rx_ready) begin
        hold++;
        if (hold == 3) begin
          chk("R9 pause held while full", ata_rd_n, 1);
          chk("R10 slack words sent", sent, HWM + 2);
          rx_ready = 1'b1;
        end
      end
      if (rx_valid && rx_ready) begin
        if (rx_data != rword(recv)) bad++;
        recv++;
      end
      if (!ata_ack_n && !ata_wr_n && sent < 10) begin
        if (!ata_rd_n) begin
          extra = 0;
          if (paused) resumed = 1'b1;
          ata_rdy = ~ata_rdy; ata_d_i = rword(sent); sent++;
        end else begin
          if (!paused) begin
            paused = 1'b1;
            chk("R9 pause at high-water mark", sent, HWM);
          end
          if (extra < 2) begin
            extra++;
            ata_rdy = ~ata_rdy; ata_d_i = rword(sent); sent++;
          end
        end
      end
    end
    chk("R8 words received", recv, 10);
    chk("R8 order and value", bad, 0);
    chk("R9 resumed after drain", resumed, 1);
    rx_ready = 1'b0;
    dma_stop = 1'b1;
    @(negedge clk);
    dma_stop = 1'b0;
    chk("R11 stop raised on read", ata_wr_n, 1);
    ata_req = 1'b0;
    @(negedge clk);
    chk("R11 ack released on read", ata_ack_n, 1);
    @(negedge clk);
    chk("R11 read burst finished", dma_active, 0);
    idle_check("after read burst");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("after reset");
    chk("R1 no burst after reset", dma_active, 0);
    chk("R8 receive stream empty", rx_valid, 0);
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VT[i];
      run_reg(v);
    end
    write_burst();
    read_burst();
    run_reg(VT[1]);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule